// File: doc/BRIEF.md
# Multi-Register Zip/Unzip Interleaver

This block owns a small register file and runs interleave commands over it. A zip command merges one, two or three source streams into one packed destination vector. An unzip command splits one packed vector back into one, two or three streams. The number of streams is the interleave factor k. It is set for each command by which of the two optional base fields are zero.

Each element can be a group of one to four adjacent registers. A group is indexed and copied as a single unit. Every register that is moved passes through a width converter. The converter either zero-extends or truncates the value, or it clamps the value to the destination range as a signed or an unsigned number.

The register file is loaded and read through a simple host port. One register is moved per clock cycle. A one-cycle done pulse marks the end of each command.

Top module: `zip_interleaver`

## Requirements
- R1: After reset, `busy` and `done` are low and every register in the file reads zero.
- R2: The interleave factor k is 1 when `cmd_rb` is zero, whatever the value of `cmd_ra`. With k=1, zip copies element RC+i to element RT+i for i from 0 to VL-1.
- R3: With `cmd_rb` nonzero and `cmd_ra` zero, k is 2. Zip then writes RB+i to packed slot 2i and RC+i to slot 2i+1, with packed slots counted from RT.
- R4: With both `cmd_rb` and `cmd_ra` nonzero, k is 3. Zip then writes RB+i, RC+i and RA+i to packed slots 3i, 3i+1 and 3i+2.
- R5: Unzip (`cmd_unzip`=1) reads packed slot k*i+j counted from RC and writes it to element i of stream j. For k=1 the only stream is at RT. For k=2 the streams are RB then RT. For k=3 the streams are RB, RT, RA.
- R6: `cmd_grp` holds the group size minus one (0 to 3). Element e of a vector at base b occupies registers b+e*G to b+e*G+G-1, where G is the group size. All register addresses wrap modulo the file depth.
- R7: The width codes `cmd_srcw` and `cmd_dstw` select 8, 16 or 32 bits (codes 0, 1, 2). Without saturation, the low source-width bits are zero-extended, or truncated to the destination width. Bits above the destination width are written as zero.
- R8: With saturation on and `cmd_signed` low, the source field is read as unsigned and clamped to the range 0 to 2^w-1, where w is the destination width.
- R9: With saturation on and `cmd_signed` high, the source field is read as two's complement and clamped to the range -2^(w-1) to 2^(w-1)-1. The result is stored as a w-bit pattern, with zeros above it.
- R10: A command with VL nonzero keeps `busy` high for VL*k*G cycles. `done` pulses for one cycle after the final write. A command with VL=0 pulses `done` on the next cycle and writes nothing.
- R11: While `busy` is high, both `cmd_start` and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write enable |
| host_waddr | input | AW | Host write address |
| host_wdata | input | DW | Host write data |
| host_raddr | input | AW | Host read address |
| host_rdata | output | DW | Combinational read data |
| cmd_start | input | 1 | Launch a command (taken only when idle) |
| cmd_unzip | input | 1 | 0 selects zip, 1 selects unzip |
| cmd_rt | input | AW | RT base field |
| cmd_rc | input | AW | RC base field |
| cmd_rb | input | AW | RB base field (zero reduces k) |
| cmd_ra | input | AW | RA base field (zero reduces k) |
| cmd_vl | input | VLW | Vector length in elements |
| cmd_grp | input | 2 | Group size minus one |
| cmd_srcw | input | 2 | Source width code |
| cmd_dstw | input | 2 | Destination width code |
| cmd_sat | input | 1 | Saturation enable |
| cmd_signed | input | 1 | Signed saturation select |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A command is captured on the first edge where `cmd_start` is seen while idle. Each move then writes its register on the following edge, so `done` is due exactly VL*k*G+1 falling edges after that capture. A command with VL=0 gives `done` on the first falling edge. The bench counts falling edges from the capture to measure this, and checks that `done` is low again one edge later. Register contents are compared only after `done`, through the combinational read port, against a bench-side model of the mapping and the width converter.

// File: rtl/zip_interleaver.sv
module zip_interleaver #(
  parameter int DW = 32,
  parameter int NREG = 32,
  parameter int VLW = 5,
  localparam int AW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [AW-1:0]  host_waddr,
  input  logic [DW-1:0]  host_wdata,
  input  logic [AW-1:0]  host_raddr,
  output logic [DW-1:0]  host_rdata,
  input  logic           cmd_start,
  input  logic           cmd_unzip,
  input  logic [AW-1:0]  cmd_rt,
  input  logic [AW-1:0]  cmd_rc,
  input  logic [AW-1:0]  cmd_rb,
  input  logic [AW-1:0]  cmd_ra,
  input  logic [VLW-1:0] cmd_vl,
  input  logic [1:0]     cmd_grp,
  input  logic [1:0]     cmd_srcw,
  input  logic [1:0]     cmd_dstw,
  input  logic           cmd_sat,
  input  logic           cmd_signed,
  output logic           busy,
  output logic           done
);

  localparam int XW = AW + VLW + 6;
  localparam int EW = DW + 2;

  function automatic int wbits(input logic [1:0] c);
    int w;
    w = 8 << c;
    return (w > DW) ? DW : w;
  endfunction

  function automatic logic [DW-1:0] lowmask(input int w);
    if (w >= DW) return '1;
    return DW'((EW'(1) << w) - EW'(1));
  endfunction

  logic [DW-1:0]  rf [NREG];
  logic           busy_q, done_q;
  logic           unzip_q, sat_q, sgn_q;
  logic [AW-1:0]  rt_q, rc_q, rb_q, ra_q;
  logic [VLW-1:0] vl_q, i_q;
  logic [1:0]     grp_q, srcw_q, dstw_q, k_q, j_q, s_q;

  logic [AW-1:0]  mid, pbase, sbase, pk_addr, st_addr, src_addr, dst_addr;
  logic [XW-1:0]  gsize, pk_off, st_off, pk_sum, st_sum;
  logic           last;

  assign gsize  = XW'(grp_q) + XW'(1);
  assign pk_off = (XW'(i_q) * XW'(k_q) + XW'(j_q)) * gsize + XW'(s_q);
  assign st_off = XW'(i_q) * gsize + XW'(s_q);

  assign mid    = unzip_q ? rt_q : rc_q;
  assign pbase  = unzip_q ? rc_q : rt_q;
  assign sbase  = (k_q == 2'd1 || j_q == 2'd1) ? mid : ((j_q == 2'd0) ? rb_q : ra_q);
  assign pk_sum = XW'(pbase) + pk_off;
  assign st_sum = XW'(sbase) + st_off;
  assign pk_addr = pk_sum[AW-1:0];
  assign st_addr = st_sum[AW-1:0];
  assign src_addr = unzip_q ? pk_addr : st_addr;
  assign dst_addr = unzip_q ? st_addr : pk_addr;

  assign last = (s_q == grp_q) && (j_q == k_q - 2'd1) && (i_q == vl_q - VLW'(1));

  int                    sw, dw;
  logic [DW-1:0]         fld, smask, res;
  logic signed [EW-1:0]  val, hi, lo;

  always_comb begin
    sw    = wbits(srcw_q);
    dw    = wbits(dstw_q);
    smask = lowmask(sw);
    fld   = rf[src_addr] & smask;
    val   = $signed({2'b00, fld});
    hi    = '0;
    lo    = '0;
    if (sat_q && sgn_q && |(fld & (smask & ~(smask >> 1))))
      val = val - (EW'(1) << sw);
    if (sat_q) begin
      if (sgn_q) begin
        hi = (EW'(1) << (dw - 1)) - EW'(1);
        lo = '0 - (EW'(1) << (dw - 1));
      end else begin
        hi = (EW'(1) << dw) - EW'(1);
        lo = '0;
      end
      if (val > hi) val = hi;
      else if (val < lo) val = lo;
    end
    res = val[DW-1:0] & lowmask(dw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NREG; n++) rf[n] <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      unzip_q <= 1'b0;
      sat_q <= 1'b0;
      sgn_q <= 1'b0;
      rt_q <= '0;
      rc_q <= '0;
      rb_q <= '0;
      ra_q <= '0;
      vl_q <= '0;
      i_q <= '0;
      grp_q <= '0;
      srcw_q <= '0;
      dstw_q <= '0;
      k_q <= 2'd1;
      j_q <= '0;
      s_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        rf[dst_addr] <= res;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (s_q != grp_q) begin
          s_q <= s_q + 2'd1;
        end else begin
          s_q <= '0;
          if (j_q != k_q - 2'd1) begin
            j_q <= j_q + 2'd1;
          end else begin
            j_q <= '0;
            i_q <= i_q + VLW'(1);
          end
        end
      end else begin
        if (host_we) rf[host_waddr] <= host_wdata;
        if (cmd_start) begin
          unzip_q <= cmd_unzip;
          rt_q <= cmd_rt;
          rc_q <= cmd_rc;
          rb_q <= cmd_rb;
          ra_q <= cmd_ra;
          vl_q <= cmd_vl;
          grp_q <= cmd_grp;
          srcw_q <= cmd_srcw;
          dstw_q <= cmd_dstw;
          sat_q <= cmd_sat;
          sgn_q <= cmd_signed;
          k_q <= (cmd_rb == '0) ? 2'd1 : ((cmd_ra == '0) ? 2'd2 : 2'd3);
          i_q <= '0;
          j_q <= '0;
          s_q <= '0;
          if (cmd_vl == '0) done_q <= 1'b1;
          else busy_q <= 1'b1;
        end
      end
    end
  end

  assign host_rdata = rf[host_raddr];
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/zip_interleaver_chk.sv
module zip_interleaver_chk #(
  parameter int VLW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_start,
  input logic [VLW-1:0] cmd_vl,
  input logic           busy,
  input logic           done
);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(cmd_start && cmd_vl == '0) |=> !done);

  // R10
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !busy && cmd_vl != '0 |=> busy);

  // R10
  empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !busy && cmd_vl == '0 |=> done && !busy);

  // R11
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));

  // R11
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_start |=> busy || done);

endmodule

bind zip_interleaver zip_interleaver_chk #(.VLW(VLW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cmd_start(cmd_start),
  .cmd_vl(cmd_vl),
  .busy(busy),
  .done(done)
);

// File: tb/zip_interleaver_tb.sv
`timescale 1ns/1ps
module zip_interleaver_tb;

  typedef struct packed {
    logic       uz;
    logic [4:0] rt, rc, rb, ra, vl;
    logic [1:0] grp, sw, dw;
    logic       sat, sgn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd20, 5'd4, 5'd0,  5'd0,  5'd6, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd2},  // R2 copy
    '{1'b0, 5'd16, 5'd8, 5'd2,  5'd0,  5'd5, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd3},  // R3 pair
    '{1'b0, 5'd17, 5'd6, 5'd1,  5'd11, 5'd4, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd4},  // R4 triple
    '{1'b1, 5'd20, 5'd1, 5'd14, 5'd26, 5'd4, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd5},  // R5 k=3
    '{1'b1, 5'd16, 5'd3, 5'd24, 5'd0,  5'd4, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd5},  // R5 k=2
    '{1'b0, 5'd16, 5'd6, 5'd1,  5'd0,  5'd2, 2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 4'd6},  // R6 pairs of regs
    '{1'b1, 5'd18, 5'd2, 5'd0,  5'd0,  5'd3, 2'd3, 2'd2, 2'd2, 1'b0, 1'b0, 4'd6},  // R6 groups of four
    '{1'b0, 5'd12, 5'd1, 5'd0,  5'd0,  5'd8, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 4'd7},  // R7 widen
    '{1'b0, 5'd14, 5'd2, 5'd0,  5'd0,  5'd8, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 truncate
    '{1'b0, 5'd15, 5'd3, 5'd0,  5'd0,  5'd9, 2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 4'd8},  // R8 unsigned clamp
    '{1'b0, 5'd18, 5'd5, 5'd0,  5'd0,  5'd10,2'd0, 2'd1, 2'd0, 1'b1, 1'b1, 4'd9},  // R9 signed clamp
    '{1'b0, 5'd16, 5'd0, 5'd0,  5'd0,  5'd8, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1, 4'd9},  // R9 sign extend
    '{1'b0, 5'd20, 5'd3, 5'd0,  5'd9,  5'd5, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd2}   // R2 RA ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [4:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        cmd_start = 1'b0;
  logic        cmd_unzip = 1'b0;
  logic [4:0]  cmd_rt = '0, cmd_rc = '0, cmd_rb = '0, cmd_ra = '0, cmd_vl = '0;
  logic [1:0]  cmd_grp = '0, cmd_srcw = '0, cmd_dstw = '0;
  logic        cmd_sat = 1'b0, cmd_signed = 1'b0;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdl [32];

  always #2 clk = ~clk;

  zip_interleaver u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .cmd_start(cmd_start), .cmd_unzip(cmd_unzip),
    .cmd_rt(cmd_rt), .cmd_rc(cmd_rc), .cmd_rb(cmd_rb), .cmd_ra(cmd_ra),
    .cmd_vl(cmd_vl), .cmd_grp(cmd_grp), .cmd_srcw(cmd_srcw), .cmd_dstw(cmd_dstw),
    .cmd_sat(cmd_sat), .cmd_signed(cmd_signed),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [31:0] x, input int sw, input int dw,
                                       input bit sat, input bit sgn);
    longint v, hi, lo;
    v = longint'(x) & ((longint'(1) << sw) - 1);
    if (sat && sgn && v >= (longint'(1) << (sw - 1))) v = v - (longint'(1) << sw);
    if (sat) begin
      hi = sgn ? (longint'(1) << (dw - 1)) - 1 : (longint'(1) << dw) - 1;
      lo = sgn ? -(longint'(1) << (dw - 1)) : 0;
      if (v > hi) v = hi;
      if (v < lo) v = lo;
    end
    v = v & ((longint'(1) << dw) - 1);
    return v[31:0];
  endfunction

  function automatic int kof(input vec_t v);
    if (v.rb == 0) return 1;
    if (v.ra == 0) return 2;
    return 3;
  endfunction

  task automatic model_run(input vec_t v);
    int k, g, sb, pa, sa, swb, dwb;
    k = kof(v);
    g = int'(v.grp) + 1;
    swb = 8 << v.sw;
    dwb = 8 << v.dw;
    for (int i = 0; i < int'(v.vl); i++)
      for (int j = 0; j < k; j++)
        for (int s = 0; s < g; s++) begin
          if (k == 1 || j == 1) sb = v.uz ? int'(v.rt) : int'(v.rc);
          else sb = (j == 0) ? int'(v.rb) : int'(v.ra);
          pa = ((v.uz ? int'(v.rc) : int'(v.rt)) + (i * k + j) * g + s) & 31;
          sa = (sb + i * g + s) & 31;
          if (v.uz) mdl[sa] = conv(mdl[pa], swb, dwb, v.sat, v.sgn);
          else      mdl[pa] = conv(mdl[sa], swb, dwb, v.sat, v.sgn);
        end
  endtask

  task automatic load(input int seed);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_waddr = 5'(a);
      host_wdata = 32'(a + 1) * 32'h9E3779B9 + 32'(seed) * 32'h7F4A7C15;
      mdl[a] = host_wdata;
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    cmd_unzip = v.uz; cmd_rt = v.rt; cmd_rc = v.rc; cmd_rb = v.rb; cmd_ra = v.ra;
    cmd_vl = v.vl; cmd_grp = v.grp; cmd_srcw = v.sw; cmd_dstw = v.dw;
    cmd_sat = v.sat; cmd_signed = v.sgn;
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < 32; a++) begin
      host_raddr = 5'(a);
      #0.5;
      chk(host_rdata === mdl[a], req, $sformatf("reg %0d", a), host_rdata, mdl[a]);
    end
  endtask

  task automatic run(input vec_t v, input string req, input bit inject);
    int cyc, expc;
    vec_t other;
    @(negedge clk);
    drive(v);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      if (inject && cyc == 3) begin
        // R11: host write and a second start while busy
        other = v;
        other.vl = 5'd0;
        drive(other);
        cmd_start = 1'b1;
        host_we = 1'b1;
        host_waddr = 5'd31;
        host_wdata = 32'hDEADBEEF;
      end else begin
        cmd_start = 1'b0;
        host_we = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_start = 1'b0;
    host_we = 1'b0;
    expc = int'(v.vl) * kof(v) * (int'(v.grp) + 1) + 1;
    chk(cyc == expc, req, "done latency", 32'(cyc), 32'(expc));
    model_run(v);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done pulse width", {31'd0, done}, 32'd0);
    compare_all(req);
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1", "busy after reset", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);
    for (int a = 0; a < 32; a++) mdl[a] = '0;
    compare_all("R1");

    for (int n = 0; n < NV; n++) begin
      load(n + 1);
      run(TBL[n], $sformatf("R%0d", TBL[n].req), 1'b0);
    end

    // R10: zero-length command
    load(40);
    v = TBL[0];
    v.vl = 5'd0;
    run(v, "R10", 1'b0);

    // R11: start and host write ignored mid-run
    load(41);
    v = '{1'b0, 5'd0, 5'd16, 5'd12, 5'd20, 5'd2, 2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 4'd11};
    run(v, "R11", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule